// File: doc/BRIEF.md
# Processor Bus Hand-over Arbiter

This block sits beside a processor's bus interface and decides when the processor lets go of the system bus. External masters ask for the bus on an active-low request line. That line may be the wired OR of several masters. The arbiter answers on an active-low grant line, which tells the master that the bus will be free once the current processor bus cycle ends. It also drives an ownership signal, `cpu_owns`, which tells the processor's bus interface whether it may drive the bus.

Two handshakes are supported:
- **Three-wire mode:** the new master confirms that it has taken the bus with an active-low acknowledge.
- **Two-wire mode:** there is no acknowledge, and the master keeps its request asserted for as long as it holds the bus.

The local bus-cycle sequencer supplies two inputs. `cyc_bound` is high at a cycle boundary, when no cycle is in flight. `rmw_lock` is high during an indivisible read-modify-write sequence. The bus is handed over only at a boundary outside such a sequence.

In three-wire mode, grant is withdrawn a fixed number of clocks after the acknowledge arrives. If the ORed request is still asserted, grant is asserted again after a further delay while the current master still holds the bus. This lets outside priority logic pick the next master early.

Request and acknowledge pass through two-flop synchronizers. Every pin-to-output delay below therefore includes two synchronizer clocks and one state-register clock. The mode pin may change only while reset is asserted.

Top module: `bus_handover_arb`

## Requirements
- R1: While reset is asserted and after it is released, with no request, `grant_n` is 1 and `cpu_owns` is 1.
- R2: After `req_n` falls, `grant_n` falls exactly 3 clocks later and not before. `cpu_owns` is still 1 at that point.
- R3: When `cyc_bound` is 1 and `rmw_lock` is 0, `cpu_owns` falls on the clock after grant is asserted. `cpu_owns` only ever falls from a clock in which grant was asserted, `cyc_bound` was 1 and `rmw_lock` was 0.
- R4: While `rmw_lock` is 1, grant stays asserted and `cpu_owns` stays 1. `cpu_owns` falls on the clock after `rmw_lock` returns to 0.
- R5: In three-wire mode (`two_wire` = 0), `grant_n` rises exactly 3+NEG_DLY clocks after `ack_n` falls, while `cpu_owns` stays 0.
- R6: In three-wire mode, with no request pending, `cpu_owns` rises exactly 3 clocks after `ack_n` rises, and grant stays negated.
- R7: In two-wire mode (`two_wire` = 1), grant stays asserted for as long as the master holds the bus, and `ack_n` has no effect. `grant_n` and `cpu_owns` both rise exactly 3 clocks after `req_n` rises.
- R8: In three-wire mode, if the request is still asserted when grant is withdrawn, `grant_n` falls again exactly REARM_DLY clocks later, while `cpu_owns` stays 0.
- R9: If grant is pending again when the current master releases the bus (`ack_n` rises), `cpu_owns` is 1 for exactly one clock, 3 clocks after the release. Grant stays asserted throughout, and the bus is then handed over again at the boundary.
- R10: A request withdrawn before the acknowledge arrives negates grant exactly 3 clocks after `req_n` rises. If the hand-over had not yet happened, `cpu_owns` stays 1 throughout. If it had, `cpu_owns` returns to 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_wire | input | 1 | 1 selects the two-wire handshake; static outside reset |
| req_n | input | 1 | Active-low bus request, possibly the wired OR of several masters |
| ack_n | input | 1 | Active-low grant acknowledge; tied high in two-wire mode |
| cyc_bound | input | 1 | High when the sequencer is at a bus-cycle boundary |
| rmw_lock | input | 1 | High during an indivisible read-modify-write sequence |
| grant_n | output | 1 | Active-low bus grant |
| cpu_owns | output | 1 | High while the processor may drive the bus |

## Verification
The bench sweeps both modes, several lengths of read-modify-write lock, and both a single master and a request that is still held when grant is withdrawn. It samples each output one clock before and on the clock where it must change.

Each failure mode shows up differently:
- A design that hands over without waiting for the lock drops `cpu_owns` while `rmw_lock` is high.
- A design with a wrong synchronizer depth shows its edges one clock early or late.
- A design that omits re-arming leaves grant negated while the ORed request stays asserted.
- A design that listens to the acknowledge in two-wire mode withdraws grant while the master still holds the bus.

Withdrawing a request before the acknowledge arrives checks that grant falls back and that ownership is never lost.

// File: rtl/bus_handover_arb.sv
module bus_handover_arb #(
  parameter int NEG_DLY   = 1,
  parameter int REARM_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic two_wire,
  input  logic req_n,
  input  logic ack_n,
  input  logic cyc_bound,
  input  logic rmw_lock,
  output logic grant_n,
  output logic cpu_owns
);
  localparam int MAXD  = (NEG_DLY > REARM_DLY) ? NEG_DLY : REARM_DLY;
  localparam int CNT_W = $clog2(MAXD + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_GRANT, S_OFF, S_ACKD, S_HELD, S_PEND
  } st_t;

  logic [1:0] req_sync, ack_sync;
  logic req_s, ack_s;
  st_t st, st_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_sync <= 2'b11;
      ack_sync <= 2'b11;
    end else begin
      req_sync <= {req_sync[0], req_n};
      ack_sync <= {ack_sync[0], ack_n | two_wire};
    end

  assign req_s = ~req_sync[1];
  assign ack_s = ~ack_sync[1];

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    case (st)
      S_IDLE:  if (req_s) st_nx = S_GRANT;
      S_GRANT: if (!req_s) st_nx = S_IDLE;
               else if (cyc_bound && !rmw_lock) st_nx = S_OFF;
      S_OFF:   if (!two_wire && ack_s) begin
                 st_nx  = S_ACKD;
                 cnt_nx = '0;
               end else if (!req_s) st_nx = S_IDLE;
      S_ACKD:  if (cnt == CNT_W'(NEG_DLY - 1)) begin
                 st_nx  = S_HELD;
                 cnt_nx = '0;
               end else cnt_nx = cnt + 1'b1;
      S_HELD:  if (!ack_s) st_nx = req_s ? S_GRANT : S_IDLE;
               else if (req_s) begin
                 if (cnt == CNT_W'(REARM_DLY - 1)) st_nx = S_PEND;
                 else cnt_nx = cnt + 1'b1;
               end
      S_PEND:  if (!ack_s) st_nx = S_GRANT;
               else if (!req_s) begin
                 st_nx  = S_HELD;
                 cnt_nx = '0;
               end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end

  assign grant_n  = !(st == S_GRANT || st == S_OFF || st == S_ACKD || st == S_PEND);
  assign cpu_owns = (st == S_IDLE || st == S_GRANT);

  assert_grant_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant_n) |-> $past(req_s));
  assert_handoff_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_owns) |-> $past(!grant_n && cyc_bound && !rmw_lock));
  assert_neg_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!two_wire && !cpu_owns && $rose(grant_n)) |-> $past(ack_s));
  assert_release_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_owns) |-> $past(two_wire ? !req_s : !ack_s || !req_s));
  assert_lock_holds_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rmw_lock && cpu_owns) |=> cpu_owns);
endmodule

// File: tb/bus_handover_arb_tb.sv
module bus_handover_arb_tb_top;
  localparam int NEG_DLY = 1;
  localparam int REARM_DLY = 2;

  logic clk = 0, rst_n = 0;
  logic two_wire = 0, req_n = 1, ack_n = 1, cyc_bound = 1, rmw_lock = 0;
  logic grant_n, cpu_owns;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_handover_arb #(.NEG_DLY(NEG_DLY), .REARM_DLY(REARM_DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .two_wire(two_wire), .req_n(req_n), .ack_n(ack_n),
    .cyc_bound(cyc_bound), .rmw_lock(rmw_lock), .grant_n(grant_n), .cpu_owns(cpu_owns));

  task automatic chk(string req, logic g_exp, logic o_exp);
    n_run++;
    if (grant_n !== g_exp || cpu_owns !== o_exp) begin
      n_fail++;
      $display("FAIL %s: grant_n=%b cpu_owns=%b expected grant_n=%b cpu_owns=%b",
               req, grant_n, cpu_owns, g_exp, o_exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(logic mode);
    @(negedge clk);
    rst_n = 0; two_wire = mode; req_n = 1; ack_n = 1; cyc_bound = 1; rmw_lock = 0;
    edges(2);
    chk("R1 in reset", 1, 1);
    @(negedge clk); rst_n = 1;
    edges(2);
    chk("R1 after reset", 1, 1);
  endtask

  task automatic request_and_handoff(int lock_len);
    @(negedge clk); rmw_lock = (lock_len > 0); req_n = 0;
    edges(2);  chk("R2 not early", 1, 1);
    edges(1);  chk("R2 grant", 0, 1);
    if (lock_len > 0) begin
      for (int k = 0; k < lock_len; k++) begin
        edges(1); chk("R4 locked", 0, 1);
      end
      @(negedge clk); rmw_lock = 0;
    end
    edges(1);  chk("R3 handoff", 0, 0);
  endtask

  initial begin
    // three-wire sweep: lock length x single master / held request
    for (int lk = 0; lk < 4; lk++) begin
      for (int held = 0; held < 2; held++) begin
        do_reset(0);
        request_and_handoff(lk);
        @(negedge clk); ack_n = 0; if (held == 0) req_n = 1;
        edges(2 + NEG_DLY); chk("R5 before neg", 0, 0);
        edges(1);           chk("R5 grant neg", 1, 0);
        if (held == 0) begin
          @(negedge clk); ack_n = 1;
          edges(2); chk("R6 before release", 1, 0);
          edges(1); chk("R6 release", 1, 1);
          edges(2); chk("R6 stays", 1, 1);
        end else begin
          edges(REARM_DLY - 1); chk("R8 before rearm", 1, 0);
          edges(1);             chk("R8 rearm", 0, 0);
          @(negedge clk); ack_n = 1;
          edges(2); chk("R9 before release", 0, 0);
          edges(1); chk("R9 one cycle own", 0, 1);
          edges(1); chk("R9 next handoff", 0, 0);
          @(negedge clk); req_n = 1;
          edges(2); chk("R10 before withdraw", 0, 0);
          edges(1); chk("R10 withdraw after handoff", 1, 1);
        end
      end
    end
    // two-wire sweep over hold length
    for (int h = 1; h <= 4; h++) begin
      do_reset(1);
      request_and_handoff(0);
      @(negedge clk); ack_n = 0;
      for (int k = 0; k < h + 3; k++) begin
        edges(1); chk("R7 hold, ack ignored", 0, 0);
      end
      @(negedge clk); ack_n = 1; req_n = 1;
      edges(2); chk("R7 before release", 0, 0);
      edges(1); chk("R7 release", 1, 1);
    end
    // withdraw before hand-over
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      @(negedge clk); rmw_lock = 1; req_n = 0;
      edges(3); chk("R2 grant under lock", 0, 1);
      @(negedge clk); req_n = 1;
      edges(2); chk("R10 before withdraw", 0, 1);
      edges(1); chk("R10 withdraw", 1, 1);
      @(negedge clk); rmw_lock = 0;
      edges(3); chk("R10 owns kept", 1, 1);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule